// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block takes an interrupt into a small processor model that uses 16-bit segment and offset registers and a 20-bit physical address. Three request sources compete for it. The first is a non-maskable line, which is detected on its rising edge. The second is a level-sensitive maskable line, gated by the interrupt-enable bit of the flags register. The third is a software strobe that carries an 8-bit vector number. Once a request is accepted, the sequencer reads the handler's far address from the vector table at the bottom of memory. It then pushes the flags, the code segment and the instruction offset onto the stack, and finally loads the handler location and clears the enable bit.

A separate return strobe runs the reverse sequence. It pops the offset, then the segment, then the flags from the stack, which restores the state saved on entry. All memory traffic goes through one word-wide port. A transfer completes on a cycle in which both the request and the ready input are high, and read data is sampled in that same cycle. The stack segment is a fixed parameter. The stack pointer, code segment, instruction offset and flags are visible as outputs.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy and mem_req are low, and cur_cs, cur_ip, cur_sp and cur_flags hold their reset parameter values.
- R2: An entry for vector v first reads the word at byte address 4*v (the new offset) and then the word at 4*v+2 (the new segment). Both reads lie below byte address 1024.
- R3: After the table reads, an entry writes three words: flags, then code segment, then instruction offset. Each write goes to physical address SS*16 + (SP-2), and SP is decremented by 2 as each write completes.
- R4: At the end of an entry, cur_cs and cur_ip hold the segment and offset read from the table, cur_sp is 6 below its starting value, and bit IE_BIT (default 9) of cur_flags is cleared.
- R5: The maskable line, with the vector on intr_vec, is taken only while cur_flags bit IE_BIT is set. While that bit is clear, a held request starts no memory activity.
- R6: The non-maskable line is taken on its rising edge, whatever the enable bit holds. A line held high causes exactly one entry.
- R7: A non-maskable entry uses vector NMI_VEC (default 2).
- R8: Accepting a hardware request (maskable or non-maskable) raises intr_ack for exactly one cycle, in the accept cycle while busy is still low. A software entry never raises intr_ack.
- R9: When several requests are pending, the software strobe is served first, then the non-maskable request, then the maskable one.
- R10: A return strobe reads three words at SS*16+SP, SS*16+SP+2 and SS*16+SP+4 into cur_ip, cur_cs and cur_flags in that order. SP rises by 2 per read.
- R11: busy is high from the cycle after acceptance until the new location is loaded. mem_req is low while busy is low. A request that arrives while busy is high is held and served afterwards.
- R12: While mem_req is high and mem_rdy is low, mem_req, mem_we, mem_addr and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_req | input | 1 | Maskable request, level sensitive |
| intr_vec | input | VW | Vector of the maskable request |
| intr_ack | output | 1 | One-cycle acknowledge for hardware requests |
| sw_strobe | input | 1 | Software interrupt strobe |
| sw_vec | input | VW | Software interrupt vector |
| ret_strobe | input | 1 | Return-from-interrupt strobe |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid when mem_req and mem_rdy are high |
| mem_rdy | input | 1 | Transfer completes this cycle |
| cur_cs | output | DW | Code segment |
| cur_ip | output | DW | Instruction offset |
| cur_sp | output | DW | Stack pointer |
| cur_flags | output | DW | Flags register |

## Verification
The bench keeps the default widths (16-bit words, 20-bit addresses, 8-bit vectors, enable bit 9, non-maskable vector 2). It sets the reset values to a stack segment of 0x3000, a stack pointer of 0x0100 and flags 0x0202, so the enable bit starts out set. With these values, nested entries followed by returns walk the stack down and back up inside one small stack window, and the flags with the enable bit set and cleared can both be seen coming back from the stack. A ready pattern that stalls one transfer in three brings the hold rule and multi-cycle transfers into every sequence.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_RET  = 2'd1,
    SRC_NMI  = 2'd2,
    SRC_MASK = 2'd3
  } src_e;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_VEC_LO  = 4'd1,
    ST_VEC_HI  = 4'd2,
    ST_PUSH_FL = 4'd3,
    ST_PUSH_CS = 4'd4,
    ST_PUSH_IP = 4'd5,
    ST_LOAD    = 4'd6,
    ST_POP_IP  = 4'd7,
    ST_POP_CS  = 4'd8,
    ST_POP_FL  = 4'd9
  } seq_st_e;

endpackage

// File: rtl/irq_src_arb.sv
module irq_src_arb
  import irq_seq_pkg::*;
#(
  parameter int VW      = 8,
  parameter int NMI_VEC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ie,
  input  logic          nmi_req,
  input  logic          intr_req,
  input  logic [VW-1:0] intr_vec,
  input  logic          sw_strobe,
  input  logic [VW-1:0] sw_vec,
  input  logic          ret_strobe,
  input  logic          accept,
  output logic          req_valid,
  output src_e          req_src,
  output logic [VW-1:0] req_vec
);

  localparam logic [VW-1:0] NMI_V = VW'(NMI_VEC);

  logic          nmi_d_q;
  logic          nmi_pend_q, nmi_pend_d;
  logic          sw_pend_q,  sw_pend_d;
  logic [VW-1:0] sw_vec_q;
  logic          ret_pend_q, ret_pend_d;
  logic          intr_q;
  logic [VW-1:0] intr_vec_q;
  logic          nmi_rise;
  logic          take_sw, take_ret, take_nmi;

  assign nmi_rise = nmi_req & ~nmi_d_q;

  // priority select: software, return, non-maskable, maskable
  always_comb begin
    req_valid = 1'b1;
    req_src   = SRC_SW;
    req_vec   = sw_vec_q;
    if (sw_pend_q) begin
      req_src = SRC_SW;
      req_vec = sw_vec_q;
    end else if (ret_pend_q) begin
      req_src = SRC_RET;
      req_vec = '0;
    end else if (nmi_pend_q) begin
      req_src = SRC_NMI;
      req_vec = NMI_V;
    end else if (intr_q && ie) begin
      req_src = SRC_MASK;
      req_vec = intr_vec_q;
    end else begin
      req_valid = 1'b0;
    end
  end

  assign take_sw  = accept && (req_src == SRC_SW);
  assign take_ret = accept && (req_src == SRC_RET);
  assign take_nmi = accept && (req_src == SRC_NMI);

  // a new arrival in the clearing cycle wins over the clear
  always_comb begin
    sw_pend_d  = sw_strobe  ? 1'b1 : (take_sw  ? 1'b0 : sw_pend_q);
    ret_pend_d = ret_strobe ? 1'b1 : (take_ret ? 1'b0 : ret_pend_q);
    nmi_pend_d = nmi_rise   ? 1'b1 : (take_nmi ? 1'b0 : nmi_pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_d_q    <= 1'b0;
      nmi_pend_q <= 1'b0;
      sw_pend_q  <= 1'b0;
      sw_vec_q   <= '0;
      ret_pend_q <= 1'b0;
      intr_q     <= 1'b0;
      intr_vec_q <= '0;
    end else begin
      nmi_d_q    <= nmi_req;
      nmi_pend_q <= nmi_pend_d;
      sw_pend_q  <= sw_pend_d;
      ret_pend_q <= ret_pend_d;
      intr_q     <= intr_req;
      intr_vec_q <= intr_vec;
      if (sw_strobe) begin
        sw_vec_q <= sw_vec;
      end
    end
  end

endmodule

// File: rtl/irq_mem_seq.sv
module irq_mem_seq
  import irq_seq_pkg::*;
#(
  parameter int          AW        = 20,
  parameter int          DW        = 16,
  parameter int          VW        = 8,
  parameter int          IE_BIT    = 9,
  parameter logic [15:0] RST_CS    = 16'h0000,
  parameter logic [15:0] RST_IP    = 16'h0000,
  parameter logic [15:0] RST_SS    = 16'h0000,
  parameter logic [15:0] RST_SP    = 16'h0000,
  parameter logic [15:0] RST_FLAGS = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  src_e          req_src,
  input  logic [VW-1:0] req_vec,
  output logic          accept,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic [DW-1:0] cs_q,
  output logic [DW-1:0] ip_q,
  output logic [DW-1:0] sp_q,
  output logic [DW-1:0] flags_q
);

  localparam int          SEG_SH = AW - DW;
  localparam int          TBL_PAD = AW - VW - 2;
  localparam logic [DW-1:0] WSTEP = DW'(2);
  localparam logic [DW-1:0] SS_V  = DW'(RST_SS);

  seq_st_e       st_q, st_d;
  logic [VW-1:0] vec_q;
  logic [DW-1:0] new_ip_q, new_cs_q;
  logic          xfer;
  logic [DW-1:0] stk_off;
  logic          is_push, is_pop;

  function automatic logic [AW-1:0] phys(input logic [DW-1:0] seg,
                                         input logic [DW-1:0] off);
    phys = {seg, {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, off};
  endfunction

  assign busy    = (st_q != ST_IDLE);
  assign xfer    = mem_req && mem_rdy;
  assign is_push = (st_q == ST_PUSH_FL) || (st_q == ST_PUSH_CS) || (st_q == ST_PUSH_IP);
  assign is_pop  = (st_q == ST_POP_IP) || (st_q == ST_POP_CS) || (st_q == ST_POP_FL);
  assign stk_off = is_push ? (sp_q - WSTEP) : sp_q;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    accept = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          st_d   = (req_src == SRC_RET) ? ST_POP_IP : ST_VEC_LO;
        end
      end
      ST_VEC_LO:  if (xfer) st_d = ST_VEC_HI;
      ST_VEC_HI:  if (xfer) st_d = ST_PUSH_FL;
      ST_PUSH_FL: if (xfer) st_d = ST_PUSH_CS;
      ST_PUSH_CS: if (xfer) st_d = ST_PUSH_IP;
      ST_PUSH_IP: if (xfer) st_d = ST_LOAD;
      ST_LOAD:    st_d = ST_IDLE;
      ST_POP_IP:  if (xfer) st_d = ST_POP_CS;
      ST_POP_CS:  if (xfer) st_d = ST_POP_FL;
      ST_POP_FL:  if (xfer) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // memory port drive
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st_q)
      ST_VEC_LO, ST_VEC_HI: begin
        mem_req  = 1'b1;
        mem_addr = {{TBL_PAD{1'b0}}, vec_q, (st_q == ST_VEC_HI), 1'b0};
      end
      ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = phys(SS_V, stk_off);
        case (st_q)
          ST_PUSH_FL: mem_wdata = flags_q;
          ST_PUSH_CS: mem_wdata = cs_q;
          default:    mem_wdata = ip_q;
        endcase
      end
      ST_POP_IP, ST_POP_CS, ST_POP_FL: begin
        mem_req  = 1'b1;
        mem_addr = phys(SS_V, stk_off);
      end
      default: ;
    endcase
  end

  // state and architectural registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      vec_q    <= '0;
      new_ip_q <= '0;
      new_cs_q <= '0;
      cs_q     <= DW'(RST_CS);
      ip_q     <= DW'(RST_IP);
      sp_q     <= DW'(RST_SP);
      flags_q  <= DW'(RST_FLAGS);
    end else begin
      st_q <= st_d;
      if (accept) begin
        vec_q <= req_vec;
      end
      if (xfer && (st_q == ST_VEC_LO)) begin
        new_ip_q <= mem_rdata;
      end
      if (xfer && (st_q == ST_VEC_HI)) begin
        new_cs_q <= mem_rdata;
      end
      if (xfer && is_push) begin
        sp_q <= sp_q - WSTEP;
      end else if (xfer && is_pop) begin
        sp_q <= sp_q + WSTEP;
      end
      if (st_q == ST_LOAD) begin
        cs_q            <= new_cs_q;
        ip_q            <= new_ip_q;
        flags_q[IE_BIT] <= 1'b0;
      end
      if (xfer && (st_q == ST_POP_IP)) begin
        ip_q <= mem_rdata;
      end
      if (xfer && (st_q == ST_POP_CS)) begin
        cs_q <= mem_rdata;
      end
      if (xfer && (st_q == ST_POP_FL)) begin
        flags_q <= mem_rdata;
      end
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          AW        = 20,
  parameter int          DW        = 16,
  parameter int          VW        = 8,
  parameter int          IE_BIT    = 9,
  parameter int          NMI_VEC   = 2,
  parameter logic [15:0] RST_CS    = 16'hF000,
  parameter logic [15:0] RST_IP    = 16'hFFF0,
  parameter logic [15:0] RST_SS    = 16'h0000,
  parameter logic [15:0] RST_SP    = 16'h0400,
  parameter logic [15:0] RST_FLAGS = 16'h0002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_req,
  input  logic          intr_req,
  input  logic [VW-1:0] intr_vec,
  output logic          intr_ack,
  input  logic          sw_strobe,
  input  logic [VW-1:0] sw_vec,
  input  logic          ret_strobe,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic [DW-1:0] cur_cs,
  output logic [DW-1:0] cur_ip,
  output logic [DW-1:0] cur_sp,
  output logic [DW-1:0] cur_flags
);

  logic          rst_s1_q, rst_s2_q;
  logic          req_valid;
  src_e          req_src;
  logic [VW-1:0] req_vec;
  logic          accept;

  // reset asserts at once, deasserts on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  irq_src_arb #(
    .VW      (VW),
    .NMI_VEC (NMI_VEC)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .ie         (cur_flags[IE_BIT]),
    .nmi_req    (nmi_req),
    .intr_req   (intr_req),
    .intr_vec   (intr_vec),
    .sw_strobe  (sw_strobe),
    .sw_vec     (sw_vec),
    .ret_strobe (ret_strobe),
    .accept     (accept),
    .req_valid  (req_valid),
    .req_src    (req_src),
    .req_vec    (req_vec)
  );

  irq_mem_seq #(
    .AW        (AW),
    .DW        (DW),
    .VW        (VW),
    .IE_BIT    (IE_BIT),
    .RST_CS    (RST_CS),
    .RST_IP    (RST_IP),
    .RST_SS    (RST_SS),
    .RST_SP    (RST_SP),
    .RST_FLAGS (RST_FLAGS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_vec   (req_vec),
    .accept    (accept),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rdy   (mem_rdy),
    .cs_q      (cur_cs),
    .ip_q      (cur_ip),
    .sp_q      (cur_sp),
    .flags_q   (cur_flags)
  );

  assign intr_ack = accept && ((req_src == SRC_NMI) || (req_src == SRC_MASK));

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          intr_ack,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_rdy,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] cur_sp
);

  localparam int TBL_W = VW + 2;

  // R11: no memory traffic outside a sequence
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R8: acknowledge comes in the accept cycle and starts a sequence
  p_ack_then_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack |-> !busy ##1 busy);

  // R8: acknowledge is a single-cycle pulse
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack |=> !intr_ack);

  // R2: first access after a hardware accept is a table read
  p_table_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack |=> (mem_req && !mem_we && (mem_addr[AW-1:TBL_W] == '0)));

  // R3: each completed stack write lowers SP by two
  p_sp_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_rdy) |=> (cur_sp == $past(cur_sp) - DW'(2)));

  // R12: a stalled request holds still
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_we) &&
                                $stable(mem_addr) && $stable(mem_wdata)));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .AW (AW),
  .DW (DW),
  .VW (VW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .intr_ack  (intr_ack),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_rdy   (mem_rdy),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .cur_sp    (cur_sp)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] P_CS = 16'h1000;
  localparam logic [15:0] P_IP = 16'h0050;
  localparam logic [15:0] P_SS = 16'h3000;
  localparam logic [15:0] P_SP = 16'h0100;
  localparam logic [15:0] P_FL = 16'h0202;
  localparam logic [15:0] IE_M = 16'h0200;

  logic        clk, rst_n;
  logic        nmi_req, intr_req, sw_strobe, ret_strobe;
  logic [7:0]  intr_vec, sw_vec;
  logic        intr_ack, busy, mem_req, mem_we, mem_rdy;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] cur_cs, cur_ip, cur_sp, cur_flags;

  irq_entry_seq #(
    .RST_CS (P_CS), .RST_IP (P_IP), .RST_SS (P_SS),
    .RST_SP (P_SP), .RST_FLAGS (P_FL)
  ) i_irq_entry_seq (
    .clk (clk), .rst_n (rst_n), .nmi_req (nmi_req), .intr_req (intr_req),
    .intr_vec (intr_vec), .intr_ack (intr_ack), .sw_strobe (sw_strobe),
    .sw_vec (sw_vec), .ret_strobe (ret_strobe), .busy (busy),
    .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_rdy (mem_rdy),
    .cur_cs (cur_cs), .cur_ip (cur_ip), .cur_sp (cur_sp), .cur_flags (cur_flags)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int ack_cnt = 0;
  int stall_cnt = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: vector table and a stack window
  logic [15:0] ivt [512];
  logic [15:0] stk [256];
  logic [1:0]  rdy_cnt = 2'd0;

  always @(posedge clk) rdy_cnt <= (rdy_cnt == 2'd2) ? 2'd0 : rdy_cnt + 2'd1;
  assign mem_rdy   = (rdy_cnt != 2'd0);
  assign mem_rdata = (mem_addr < 20'd1024) ? ivt[mem_addr[9:1]] : stk[mem_addr[8:1]];

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_rdy && (mem_addr[19:9] == 11'h180))
      stk[mem_addr[8:1]] <= mem_wdata;
  end

  // scoreboard queues
  logic        q_we   [$];
  logic [19:0] q_addr [$];
  logic [15:0] q_data [$];
  string       q_tag  [$];

  // reference state
  logic [15:0] m_cs, m_ip, m_sp, m_fl;
  logic [15:0] s_cs [$];
  logic [15:0] s_ip [$];
  logic [15:0] s_fl [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [19:0] sphys(input logic [15:0] off);
    sphys = {P_SS, 4'h0} + {4'h0, off};
  endfunction

  task automatic push_item(input logic we, input logic [19:0] a,
                           input logic [15:0] d, input string tag);
    q_we.push_back(we);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  task automatic exp_entry(input logic [7:0] v);
    push_item(1'b0, {10'd0, v, 2'b00}, 16'h0, "R2");
    push_item(1'b0, {10'd0, v, 2'b10}, 16'h0, "R2");
    push_item(1'b1, sphys(m_sp - 16'd2), m_fl, "R3");
    push_item(1'b1, sphys(m_sp - 16'd4), m_cs, "R3");
    push_item(1'b1, sphys(m_sp - 16'd6), m_ip, "R3");
    s_cs.push_back(m_cs);
    s_ip.push_back(m_ip);
    s_fl.push_back(m_fl);
    m_sp = m_sp - 16'd6;
    m_cs = 16'h2000 + {8'h0, v};
    m_ip = 16'h0100 + {8'h0, v};
    m_fl = m_fl & ~IE_M;
  endtask

  task automatic exp_return();
    push_item(1'b0, sphys(m_sp),          16'h0, "R10");
    push_item(1'b0, sphys(m_sp + 16'd2),  16'h0, "R10");
    push_item(1'b0, sphys(m_sp + 16'd4),  16'h0, "R10");
    m_sp = m_sp + 16'd6;
    m_ip = s_ip.pop_back();
    m_cs = s_cs.pop_back();
    m_fl = s_fl.pop_back();
  endtask

  // monitor: compare completed transfers, watch stalls
  logic        stall_seen = 1'b0;
  logic [19:0] stall_addr;
  always @(negedge clk) begin
    if (intr_ack === 1'b1) ack_cnt++;
    if (stall_seen) begin
      chk(mem_req && (mem_addr == stall_addr), "R12", "stalled address held",
          {12'h0, mem_addr}, {12'h0, stall_addr});
      stall_seen = 1'b0;
    end
    if (mem_req === 1'b1 && mem_rdy === 1'b0) begin
      stall_seen = 1'b1;
      stall_addr = mem_addr;
      stall_cnt++;
    end
    if (mem_req === 1'b1 && mem_rdy === 1'b1) begin
      if (q_we.size() == 0) begin
        chk(1'b0, "R11", "unexpected transfer", {12'h0, mem_addr}, 32'h0);
      end else begin
        automatic logic        e_we   = q_we.pop_front();
        automatic logic [19:0] e_addr = q_addr.pop_front();
        automatic logic [15:0] e_data = q_data.pop_front();
        automatic string       e_tag  = q_tag.pop_front();
        chk(mem_we == e_we, e_tag, "direction", {31'h0, mem_we}, {31'h0, e_we});
        chk(mem_addr == e_addr, e_tag, "address", {12'h0, mem_addr}, {12'h0, e_addr});
        if (e_we)
          chk(mem_wdata == e_data, e_tag, "write data", {16'h0, mem_wdata}, {16'h0, e_data});
      end
    end
  end

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while ((q_we.size() != 0 || busy) && n < 2000);
    chk(n < 2000, "R11", "sequence completion", n, 2000);
  endtask

  task automatic check_regs(input string tag);
    chk(cur_cs == m_cs, tag, "cur_cs", {16'h0, cur_cs}, {16'h0, m_cs});
    chk(cur_ip == m_ip, tag, "cur_ip", {16'h0, cur_ip}, {16'h0, m_ip});
    chk(cur_sp == m_sp, tag, "cur_sp", {16'h0, cur_sp}, {16'h0, m_sp});
    chk(cur_flags == m_fl, tag, "cur_flags", {16'h0, cur_flags}, {16'h0, m_fl});
  endtask

  task automatic pulse_sw(input logic [7:0] v);
    @(negedge clk);
    sw_strobe = 1'b1;
    sw_vec    = v;
    @(negedge clk);
    sw_strobe = 1'b0;
  endtask

  task automatic pulse_ret();
    @(negedge clk);
    ret_strobe = 1'b1;
    @(negedge clk);
    ret_strobe = 1'b0;
  endtask

  task automatic do_return(input string tag);
    exp_return();
    pulse_ret();
    wait_done();
    check_regs(tag);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int a0;
    bit seen;
    for (int i = 0; i < 256; i++) begin
      ivt[2*i]   = 16'h0100 + 16'(i);
      ivt[2*i+1] = 16'h2000 + 16'(i);
    end
    for (int i = 0; i < 256; i++) stk[i] = 16'h0;
    rst_n = 1'b0; nmi_req = 1'b0; intr_req = 1'b0; sw_strobe = 1'b0;
    ret_strobe = 1'b0; intr_vec = 8'h0; sw_vec = 8'h0;
    m_cs = P_CS; m_ip = P_IP; m_sp = P_SP; m_fl = P_FL;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", {31'h0, busy}, 32'h0);
    chk(mem_req == 1'b0, "R1", "mem_req", {31'h0, mem_req}, 32'h0);
    check_regs("R1");

    // R4 / R8: software entry, no acknowledge
    a0 = ack_cnt;
    exp_entry(8'h21);
    pulse_sw(8'h21);
    wait_done();
    check_regs("R4");
    chk(ack_cnt == a0, "R8", "software ack count", ack_cnt, a0);

    // R5: maskable blocked while enable bit is clear
    intr_vec = 8'h40;
    intr_req = 1'b1;
    seen = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (busy || mem_req) seen = 1'b1;
    end
    chk(!seen, "R5", "masked request stayed idle", {31'h0, seen}, 32'h0);
    intr_req = 1'b0;
    repeat (3) @(negedge clk);

    // R6 / R7: non-maskable edge, held high
    a0 = ack_cnt;
    exp_entry(8'd2);
    nmi_req = 1'b1;
    wait_done();
    check_regs("R7");
    chk(ack_cnt == a0 + 1, "R8", "hardware ack count", ack_cnt, a0 + 1);
    seen = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (busy || mem_req) seen = 1'b1;
    end
    chk(!seen, "R6", "held line gave one entry", {31'h0, seen}, 32'h0);
    nmi_req = 1'b0;

    // R10: two returns unwind to the reset context
    do_return("R10");
    do_return("R10");

    // R5: maskable taken with enable bit set
    a0 = ack_cnt;
    exp_entry(8'h40);
    @(negedge clk);
    intr_vec = 8'h40;
    intr_req = 1'b1;
    wait_done();
    intr_req = 1'b0;
    check_regs("R5");
    chk(ack_cnt == a0 + 1, "R8", "maskable ack count", ack_cnt, a0 + 1);
    repeat (3) @(negedge clk);
    do_return("R10");

    // R9: all three at once
    a0 = ack_cnt;
    exp_entry(8'h10);
    exp_entry(8'd2);
    @(negedge clk);
    sw_strobe = 1'b1; sw_vec = 8'h10;
    nmi_req = 1'b1;
    intr_req = 1'b1; intr_vec = 8'h41;
    @(negedge clk);
    sw_strobe = 1'b0;
    wait_done();
    repeat (5) @(negedge clk);
    intr_req = 1'b0;
    nmi_req = 1'b0;
    check_regs("R9");
    chk(ack_cnt == a0 + 1, "R9", "ack count, maskable not served", ack_cnt, a0 + 1);
    do_return("R10");
    do_return("R10");

    // R11: request arriving while busy is held
    exp_entry(8'h33);
    exp_entry(8'd2);
    pulse_sw(8'h33);
    begin
      int n = 0;
      while (!busy && n < 50) begin
        @(negedge clk);
        n++;
      end
    end
    chk(busy == 1'b1, "R11", "busy during entry", {31'h0, busy}, 32'h1);
    nmi_req = 1'b1;
    @(negedge clk);
    nmi_req = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    check_regs("R11");
    chk(q_we.size() == 0, "R11", "scoreboard drained", q_we.size(), 0);
    chk(stall_cnt > 0, "R12", "stalls exercised", stall_cnt, 1);

    finish_run();
  end

endmodule